// File: doc/BRIEF.md
# Floating-Point Trap Decision Unit

This block sits beside a floating-point datapath and decides, one operation at a time, whether an arithmetic trap must be taken. When an operation completes, the datapath reports its six exception flags together with the instruction's ignore mask, the current enable mask, a software-completion qualifier, the privilege mode and the destination register number. The unit folds the flags into a sticky exception status register, applies the trap rules for the qualifier and mode, and on a trap emits a one-cycle pulse, a summary word and a one-hot mask that names the destination register.

Before an operation starts, the same unit can screen a raw 64-bit double-precision operand. Denormals, infinities and NaNs trap differently depending on whether the instruction is a comparison, whether software completion is requested, and whether denormal inputs are flushed to zero. The arithmetic and the trap handler live elsewhere. A synchronous clear input empties the sticky register.

Top module: `fptrap_unit`

## Requirements
- R1: For an operation report without software completion, every reported flag is ORed into the sticky register, including flags set in the ignore mask.
- R2: Without software completion, a trap is raised if and only if flags AND NOT ignore is nonzero. The summary word then holds that value in bits 5..0 with bit 6 clear. The flag positions are invalid 0, divide-by-zero 1, overflow 2, underflow 3, inexact 4 and integer overflow 5. Bit 6 of the summary is the software-completion bit. The mode input has no effect here.
- R3: With software completion, only flags AND NOT ignore are ORed into the sticky register.
- R4: With software completion in user mode (`user_mode`=1), a trap is raised only if flags AND NOT ignore AND enable is nonzero. In system mode, any non-ignored flag raises a trap.
- R5: With software completion, the summary word is (flags AND NOT ignore AND enable) with bit 6 set.
- R6: On a trap from an operation report, the register mask has exactly bit `dest_reg` set. It is all zero on a screen trap and whenever `trap` is low.
- R7: The plain screen (no software completion, `scr_cmp`=0) traps with summary 0x01 on a denormal operand (exponent field zero, fraction nonzero), whatever `scr_ftz` is, and leaves the sticky register unchanged. On an exponent field of all ones it traps with summary 0x01 and also sets sticky bit 0.
- R8: The comparison screen (`scr_cmp`=1, no software completion) passes infinities untouched. It traps on a NaN, which also sets sticky bit 0, and it traps on a denormal, which does not.
- R9: With software completion, the screen traps with summary 0x41 only on a denormal magnitude of either sign, and only when `scr_ftz` is 0. It never changes the sticky register, and it passes infinities, NaNs and zeros.
- R10: `trap`, `trap_summary` and `trap_regmask` are registered. They reflect the input of the previous clock and are zero in cycles that follow no trapping input.
- R11: `sticky_clr` zeroes the sticky register at the next edge. Flags arriving in the same cycle still land in it.
- R12: When `op_valid` and `scr_valid` are both high, the operation report is used and the screen request is ignored.
- R13: After reset, `trap`, `trap_summary`, `trap_regmask` and `sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A completed operation is reported this cycle |
| op_flags | input | 6 | Exception flags of the operation |
| ign_mask | input | 6 | Flags the instruction ignores |
| en_mask | input | 6 | Trap enable mask |
| sw_comp | input | 1 | Software-completion qualifier (applies to reports and screens) |
| user_mode | input | 1 | 1 = user mode, 0 = system mode |
| dest_reg | input | 5 | Destination register number |
| scr_valid | input | 1 | Screen the operand this cycle |
| scr_operand | input | 64 | Raw double-precision operand |
| scr_cmp | input | 1 | Operand belongs to a comparison |
| scr_ftz | input | 1 | Denormal inputs are flushed to zero |
| sticky_clr | input | 1 | Synchronous clear of the sticky register |
| trap | output | 1 | One-cycle trap pulse |
| trap_summary | output | 7 | Trap summary word |
| trap_regmask | output | 32 | One-hot destination register mask |
| sticky | output | 6 | Sticky exception status |

## Verification
The bench targets the places where a flag can be ignored and still leave a trace. An ignored inexact flag must still become sticky without software completion but must not become sticky with it; a design that swapped the order of masking and the status update would fail one of these. Flags that are not enabled must trap in system mode but not in user mode, and a mode test placed on the wrong path would show up as a missing or spurious pulse. The screen cases separate infinity from NaN on the comparison path, check that flush-to-zero matters only under software completion, and check that negative denormals and signed zeros are classified correctly. A simultaneous report and screen, and a clear that coincides with new flags, cover the priority and ordering decisions.

// File: rtl/fptrap_pkg.sv
package fptrap_pkg;
   localparam int FLAG_W  = 6;
   localparam int SUM_W   = FLAG_W + 1;
   localparam int BIT_INV = 0;
   localparam int BIT_DZE = 1;
   localparam int BIT_OVF = 2;
   localparam int BIT_UNF = 3;
   localparam int BIT_INE = 4;
   localparam int BIT_IOV = 5;
   localparam int BIT_SWC = 6;

   typedef logic [FLAG_W-1:0] fx_flags_t;
   typedef logic [SUM_W-1:0]  fx_sum_t;
endpackage

// File: rtl/fptrap_opcheck.sv
module fptrap_opcheck
   import fptrap_pkg::*;
(
   input  fx_flags_t flags,
   input  fx_flags_t ign,
   input  fx_flags_t en,
   input  logic      swc,
   input  logic      user,
   output logic      hit,
   output fx_sum_t   sum,
   output fx_flags_t sticky_add
);
   fx_flags_t live;
   fx_flags_t gated;

   always_comb begin
      live  = flags & ~ign;
      gated = live & en;
      if (swc) begin
         sticky_add = live;
         hit        = user ? (|gated) : (|live);
         sum        = {1'b1, gated};
      end else begin
         sticky_add = flags;
         hit        = |live;
         sum        = {1'b0, live};
      end
   end
endmodule

// File: rtl/fptrap_screen.sv
module fptrap_screen
   import fptrap_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int OPND_W = 1 + EXP_W + FRAC_W
) (
   input  logic [OPND_W-1:0] opnd,
   input  logic              cmp,
   input  logic              swc,
   input  logic              ftz,
   output logic              hit,
   output fx_sum_t           sum,
   output fx_flags_t         sticky_add
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic exp_zero, exp_ones, frac_nz, denorm, is_nan;

   always_comb begin
      exp_f    = opnd[FRAC_W +: EXP_W];
      frac_f   = opnd[FRAC_W-1:0];
      exp_zero = ~|exp_f;
      exp_ones = &exp_f;
      frac_nz  = |frac_f;
      denorm   = exp_zero & frac_nz;
      is_nan   = exp_ones & frac_nz;
      sum        = '0;
      sticky_add = '0;
      hit        = 1'b0;
      sum[BIT_INV] = 1'b1;
      if (swc) begin
         hit          = denorm & ~ftz;
         sum[BIT_SWC] = 1'b1;
      end else if (cmp) begin
         hit                 = denorm | is_nan;
         sticky_add[BIT_INV] = is_nan;
      end else begin
         hit                 = denorm | exp_ones;
         sticky_add[BIT_INV] = exp_ones;
      end
   end
endmodule

// File: rtl/fptrap_sticky.sv
module fptrap_sticky
   import fptrap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  fx_flags_t add,
   output fx_flags_t q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (clr ? '0 : q) | add;
   end
endmodule

// File: rtl/fptrap_unit.sv
module fptrap_unit
   import fptrap_pkg::*;
#(
   parameter int NREG   = 32,
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int REG_W  = $clog2(NREG),
   localparam int OPND_W = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [5:0]        op_flags,
   input  logic [5:0]        ign_mask,
   input  logic [5:0]        en_mask,
   input  logic              sw_comp,
   input  logic              user_mode,
   input  logic [REG_W-1:0]  dest_reg,
   input  logic              scr_valid,
   input  logic [OPND_W-1:0] scr_operand,
   input  logic              scr_cmp,
   input  logic              scr_ftz,
   input  logic              sticky_clr,
   output logic              trap,
   output logic [6:0]        trap_summary,
   output logic [NREG-1:0]   trap_regmask,
   output logic [5:0]        sticky
);
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("fptrap_unit: NREG must be a power of two of at least 2");
   end
   if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fmt
      $error("fptrap_unit: operand format too narrow");
   end

   logic      op_hit, scr_hit, use_op, use_scr, hit_n;
   fx_sum_t   op_sum, scr_sum, sum_n;
   fx_flags_t op_add, scr_add, stk_add;
   logic [NREG-1:0] onehot, mask_n;

   fptrap_opcheck u_op (
      .flags(op_flags), .ign(ign_mask), .en(en_mask), .swc(sw_comp),
      .user(user_mode), .hit(op_hit), .sum(op_sum), .sticky_add(op_add)
   );

   fptrap_screen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_scr (
      .opnd(scr_operand), .cmp(scr_cmp), .swc(sw_comp), .ftz(scr_ftz),
      .hit(scr_hit), .sum(scr_sum), .sticky_add(scr_add)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign onehot[i] = (dest_reg == REG_W'(i));
   end

   always_comb begin
      use_op  = op_valid;
      use_scr = scr_valid & ~op_valid;
      hit_n   = use_op ? op_hit : (use_scr & scr_hit);
      sum_n   = !hit_n ? '0 : (use_op ? op_sum : scr_sum);
      mask_n  = (hit_n && use_op) ? onehot : '0;
      stk_add = use_op ? op_add : (use_scr ? scr_add : '0);
   end

   fptrap_sticky u_stk (
      .clk(clk), .rst_n(rst_n), .clr(sticky_clr), .add(stk_add), .q(sticky)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap         <= 1'b0;
         trap_summary <= '0;
         trap_regmask <= '0;
      end else begin
         trap         <= hit_n;
         trap_summary <= sum_n;
         trap_regmask <= mask_n;
      end
   end
endmodule

// File: rtl/fptrap_chk.sv
module fptrap_chk #(
   parameter int NREG = 32,
   parameter int OPND_W = 64,
   localparam int REG_W = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [5:0]        op_flags,
   input logic [5:0]        ign_mask,
   input logic [5:0]        en_mask,
   input logic              sw_comp,
   input logic              user_mode,
   input logic [REG_W-1:0]  dest_reg,
   input logic              scr_valid,
   input logic [OPND_W-1:0] scr_operand,
   input logic              scr_cmp,
   input logic              scr_ftz,
   input logic              sticky_clr,
   input logic              trap,
   input logic [6:0]        trap_summary,
   input logic [NREG-1:0]   trap_regmask,
   input logic [5:0]        sticky
);
   AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> $past(op_valid || scr_valid));                                   // R10
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !trap |-> (trap_summary == '0 && trap_regmask == '0));                    // R10
   AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trap_regmask));                                                   // R6
   AST_MASK_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (trap && $past(op_valid)) |-> trap_regmask == (NREG'(1) << $past(dest_reg))); // R6
   AST_SWC_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (trap && $past(op_valid && sw_comp)) |-> trap_summary[6]);                 // R5
   AST_SWC_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (trap && $past(op_valid && !sw_comp)) |-> !trap_summary[6]);               // R2
   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sticky_clr) |-> ((sticky & $past(sticky)) == $past(sticky)));       // R1
   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sticky_clr && !op_valid && !scr_valid) |-> sticky == '0);            // R11
endmodule

bind fptrap_unit fptrap_chk #(.NREG(NREG), .OPND_W(OPND_W)) u_chk (.*);

// File: tb/sim_fptrap_unit.sv
module sim_fptrap_unit;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        op_valid = 0, sw_comp = 0, user_mode = 0;
   logic [5:0]  op_flags = 0, ign_mask = 0, en_mask = 0;
   logic [4:0]  dest_reg = 0;
   logic        scr_valid = 0, scr_cmp = 0, scr_ftz = 0, sticky_clr = 0;
   logic [63:0] scr_operand = 0;
   logic        trap;
   logic [6:0]  trap_summary;
   logic [31:0] trap_regmask;
   logic [5:0]  sticky;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   fptrap_unit u0 (.*);

   typedef struct packed {
      logic swc; logic usr; logic [5:0] fl; logic [5:0] ig; logic [5:0] en;
      logic [4:0] dst; logic trp; logic [6:0] sum; logic [5:0] stk;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b0,6'h01,6'h00,6'h00,5'd3, 1'b1,7'h01,6'h01}, // R2 plain invalid
      '{1'b0,1'b0,6'h10,6'h10,6'h00,5'd4, 1'b0,7'h00,6'h10}, // R1 ignored flag still sticky
      '{1'b0,1'b0,6'h14,6'h10,6'h00,5'd31,1'b1,7'h04,6'h14}, // R2 partial ignore
      '{1'b1,1'b1,6'h10,6'h10,6'h3F,5'd5, 1'b0,7'h00,6'h00}, // R3 ignored not sticky
      '{1'b1,1'b1,6'h18,6'h00,6'h08,5'd7, 1'b1,7'h48,6'h18}, // R4 R5 user enabled
      '{1'b1,1'b1,6'h02,6'h00,6'h01,5'd9, 1'b0,7'h00,6'h02}, // R4 user not enabled
      '{1'b1,1'b0,6'h02,6'h00,6'h01,5'd12,1'b1,7'h40,6'h02}, // R4 R5 system traps anyway
      '{1'b1,1'b0,6'h30,6'h10,6'h20,5'd0, 1'b1,7'h60,6'h20}, // R3 R5 system
      '{1'b0,1'b0,6'h00,6'h00,6'h3F,5'd2, 1'b0,7'h00,6'h00}, // R2 no flags
      '{1'b0,1'b1,6'h22,6'h02,6'h00,5'd1, 1'b1,7'h20,6'h22}  // R2 mode has no effect
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      op_valid = 0; scr_valid = 0; sticky_clr = 0;
   endtask

   task automatic screen(input string req, input logic [63:0] v, input logic cmp,
                         input logic swc, input logic ftz, input logic et,
                         input logic [6:0] es, input logic [5:0] ek);
      @(negedge clk);
      idle(); sticky_clr = 1;
      @(negedge clk);
      idle(); scr_valid = 1; scr_operand = v; scr_cmp = cmp; sw_comp = swc; scr_ftz = ftz;
      @(negedge clk);
      chk({req, " trap"}, 64'(trap), 64'(et));
      chk({req, " summary"}, 64'(trap_summary), 64'(es));
      chk({req, " R6 regmask"}, 64'(trap_regmask), 64'd0);
      chk({req, " sticky"}, 64'(sticky), 64'(ek));
      idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R13 trap", 64'(trap), 0);
      chk("R13 summary", 64'(trap_summary), 0);
      chk("R13 regmask", 64'(trap_regmask), 0);
      chk("R13 sticky", 64'(sticky), 0);

      for (int i = 0; i < NV; i++) begin
         op_valid = 1; sticky_clr = 1; scr_valid = 0;
         sw_comp = TBL[i].swc; user_mode = TBL[i].usr; op_flags = TBL[i].fl;
         ign_mask = TBL[i].ig; en_mask = TBL[i].en; dest_reg = TBL[i].dst;
         @(negedge clk);
         chk("R2/R4/R10 trap", 64'(trap), 64'(TBL[i].trp));
         chk("R2/R5 summary", 64'(trap_summary), 64'(TBL[i].sum));
         chk("R6 regmask", 64'(trap_regmask),
             TBL[i].trp ? (64'd1 << TBL[i].dst) : 64'd0);
         chk("R1/R3/R11 sticky", 64'(sticky), 64'(TBL[i].stk));
      end

      // R10: outputs drop in the cycle after the trapping report
      idle();
      @(negedge clk);
      chk("R10 pulse ends", 64'(trap), 0);
      chk("R10 summary idle", 64'(trap_summary), 0);
      chk("R10 regmask idle", 64'(trap_regmask), 0);

      // R1: accumulation across reports, R11 clear alone
      sw_comp = 0; sticky_clr = 1; @(negedge clk);
      idle(); op_valid = 1; op_flags = 6'h01; ign_mask = 0; @(negedge clk);
      op_flags = 6'h08; ign_mask = 6'h08; @(negedge clk);
      chk("R1 accumulate", 64'(sticky), 64'h09);
      idle(); sticky_clr = 1; @(negedge clk);
      chk("R11 clear", 64'(sticky), 0);
      idle();

      // Operand screens: value, cmp, swc, ftz, trap, summary, sticky
      screen("R7 denorm",       64'h0000_0000_0000_0001, 0,0,0, 1,7'h01,6'h00);
      screen("R7 denorm ftz",   64'h0000_0000_0000_0001, 0,0,1, 1,7'h01,6'h00);
      screen("R7 infinity",     64'h7FF0_0000_0000_0000, 0,0,0, 1,7'h01,6'h01);
      screen("R7 normal",       64'h3FF0_0000_0000_0000, 0,0,0, 0,7'h00,6'h00);
      screen("R7 neg zero",     64'h8000_0000_0000_0000, 0,0,0, 0,7'h00,6'h00);
      screen("R8 cmp infinity", 64'hFFF0_0000_0000_0000, 1,0,0, 0,7'h00,6'h00);
      screen("R8 cmp nan",      64'h7FF8_0000_0000_0000, 1,0,0, 1,7'h01,6'h01);
      screen("R8 cmp denorm",   64'h800F_FFFF_FFFF_FFFF, 1,0,0, 1,7'h01,6'h00);
      screen("R9 swc denorm",   64'h800F_FFFF_FFFF_FFFF, 0,1,0, 1,7'h41,6'h00);
      screen("R9 swc ftz",      64'h800F_FFFF_FFFF_FFFF, 0,1,1, 0,7'h00,6'h00);
      screen("R9 swc nan",      64'h7FF8_0000_0000_0001, 0,1,0, 0,7'h00,6'h00);
      screen("R9 swc zero",     64'h8000_0000_0000_0000, 1,1,0, 0,7'h00,6'h00);

      // R12: report wins over a screen in the same cycle
      @(negedge clk);
      idle(); sticky_clr = 1; @(negedge clk);
      idle(); sw_comp = 0; op_valid = 1; op_flags = 0; ign_mask = 0;
      scr_valid = 1; scr_operand = 64'h7FF0_0000_0000_0000; scr_cmp = 0;
      @(negedge clk);
      chk("R12 trap", 64'(trap), 0);
      chk("R12 sticky", 64'(sticky), 0);
      idle();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule